// File: doc/BRIEF.md
# Grouped Simultaneous-Conversion Readout Sequencer

This block drives a bank of eight serial-output successive-approximation converters that all sample at the same instant. It selects which half of a sixteen-input bank reaches the converters. It then holds the sample-and-hold circuits for a fixed conversion time and clocks the eight results out in lock-step over eight data lines that share one serial clock. Each result goes to a downstream FIFO, tagged with the channel it came from.

After each readout the converters are back in acquire mode. A settling interval, programmed in clock cycles, must pass before the next hold begins, so the switching noise of the readout never lands inside a hold window. The eight results are written to the FIFO during this interval. A full FIFO stalls the writes and keeps the sequencer in the settling state, so no new conversion starts until there is space.

The states are IDLE, SELECT, CONVERT, READ and SETTLE. The transitions are:
- IDLE to SELECT when `enable` is high.
- SELECT to CONVERT after one cycle.
- CONVERT to READ once the conversion count expires.
- READ to SETTLE after the fourteenth serial bit.
- SETTLE to SELECT, or to IDLE if `enable` is low, once the interval has expired, all eight results are written and the FIFO is not full.

In scan mode the group alternates on every conversion. In single-group mode each SELECT entry samples `group_sel`.

Top module: `adc_group_seq`

## Requirements
- R1: While reset is held, and in IDLE, `hold`, `sclk` and `fifo_wr` are 0 and `mux_sel` is 0 after reset.
- R2: From IDLE with `enable` high, SELECT lasts one cycle. Then `hold` is high for exactly CONV_CYCLES (default 24) consecutive cycles, and `mux_sel` does not change while `hold` is high.
- R3: After `hold` falls, `sclk` makes 14 pulses. Each pulse is one cycle low followed by one cycle high, starting low. Each converter's bit is captured in the cycle `sclk` is high, most significant bit first.
- R4: After the readout, eight FIFO writes carry channels in ascending order. `fifo_data[17:14]` holds the channel number, which is group*8 plus the converter index, and `fifo_data[13:0]` holds that converter's 14-bit result.
- R5: The next `hold` starts no sooner than `settle_cycles`+2 cycles after the last high `sclk` cycle. It also waits until all eight results of the previous conversion are written.
- R6: `fifo_wr` is never high while `fifo_full` is high. While `fifo_full` is high the sequencer stays in SETTLE, and any remaining writes resume once it falls.
- R7: In scan mode the groups go 0, 1, 0, 1 and so on, starting from group 0 after IDLE. In single-group mode the group is `group_sel` as sampled when SELECT is entered.
- R8: `enable` low does not abort a conversion in progress. The sequence returns to IDLE at the end of SETTLE and stays there with `hold` low.
- R9: `sclk` is never high outside READ, and `hold` and `sclk` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run conversions while high |
| scan_mode | input | 1 | 1: alternate groups, 0: repeat `group_sel` |
| group_sel | input | 1 | Group used in single-group mode |
| settle_cycles | input | 8 | Settling interval in cycles after readout |
| fifo_full | input | 1 | Downstream FIFO cannot accept a write |
| sdata | input | 8 | One serial data line per converter |
| mux_sel | output | 1 | Input group routed to the converters |
| hold | output | 1 | Sample-and-hold in hold / conversion running |
| sclk | output | 1 | Shared serial readout clock |
| fifo_wr | output | 1 | Write strobe for one tagged result |
| fifo_data | output | 18 | {channel[3:0], result[13:0]} |

## Verification
Result writes and the settling countdown fall in the same cycles of SETTLE. With a short interval the writes decide when SETTLE ends; with a long one the countdown does. The bench provokes both cases and also asserts `fifo_full` in patterns that land on writes and on the final cycle of the interval. A behavioural model predicts every output each cycle, and a queue filled with the values the bench's own converters present confirms the contents and order of the writes.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_CONVERT,
        ST_READ,
        ST_SETTLE
    } seq_state_t;

endpackage

// File: rtl/adcseq_lane.sv
// One converter's serial-to-parallel capture register, MSB first.
module adcseq_lane #(
    parameter int RES_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             sdata_bit,
    output logic [RES_W-1:0] word
);

    logic [RES_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (shift_en) begin
            shreg <= {shreg[RES_W-2:0], sdata_bit};
        end
    end

    assign word = shreg;

endmodule

// File: rtl/adcseq_ctrl.sv
// Sequencing FSM: group select, conversion timing, serial clocking, settle and push.
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int NUM_CONV    = 8,
    parameter int RES_W       = 14,
    parameter int CONV_CYCLES = 24,
    parameter int SETTLE_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable,
    input  logic                        scan_mode,
    input  logic                        group_sel,
    input  logic [SETTLE_W-1:0]         settle_cycles,
    input  logic                        fifo_full,
    output logic                        hold,
    output logic                        sclk,
    output logic                        shift_en,
    output logic                        mux_sel,
    output logic                        fifo_wr,
    output logic [$clog2(NUM_CONV)-1:0] lane_idx
);

    localparam int LANE_W = $clog2(NUM_CONV);
    localparam int IDX_W  = $clog2(NUM_CONV + 1);
    localparam int BIT_W  = $clog2(RES_W);
    localparam int CV_W   = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam int CNT_W  = (SETTLE_W > CV_W) ? SETTLE_W : CV_W;

    seq_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [BIT_W-1:0] bit_cnt;
    logic             sclk_q;
    logic             mux_q;
    logic             scan_next;
    logic [IDX_W-1:0] push_idx;
    logic             grp_pick;
    logic             settle_done;
    logic             read_last;
    logic             push_valid;

    assign grp_pick    = scan_mode ? scan_next : group_sel;
    assign read_last   = sclk_q && (bit_cnt == BIT_W'(RES_W - 1));
    assign settle_done = (cnt == '0) && (push_idx == IDX_W'(NUM_CONV)) && !fifo_full;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (enable) state_nx = ST_SELECT;
            ST_SELECT:  state_nx = ST_CONVERT;
            ST_CONVERT: if (cnt == '0) state_nx = ST_READ;
            ST_READ:    if (read_last) state_nx = ST_SETTLE;
            ST_SETTLE:  if (settle_done) state_nx = enable ? ST_SELECT : ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Counters, serial clock, group bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            bit_cnt   <= '0;
            sclk_q    <= 1'b0;
            mux_q     <= 1'b0;
            scan_next <= 1'b0;
            push_idx  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (enable) begin
                        mux_q     <= grp_pick;
                        scan_next <= ~grp_pick;
                    end
                end
                ST_SELECT: begin
                    cnt <= CNT_W'(CONV_CYCLES - 1);
                end
                ST_CONVERT: begin
                    if (cnt != '0) begin
                        cnt <= cnt - CNT_W'(1);
                    end else begin
                        bit_cnt <= '0;
                        sclk_q  <= 1'b0;
                    end
                end
                ST_READ: begin
                    sclk_q <= ~sclk_q;
                    if (sclk_q) begin
                        bit_cnt <= bit_cnt + BIT_W'(1);
                        if (read_last) begin
                            cnt      <= CNT_W'(settle_cycles);
                            push_idx <= '0;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (fifo_wr) push_idx <= push_idx + IDX_W'(1);
                    if (cnt != '0) cnt <= cnt - CNT_W'(1);
                    if (settle_done) begin
                        if (enable) begin
                            mux_q     <= grp_pick;
                            scan_next <= ~grp_pick;
                        end else begin
                            scan_next <= 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        hold       = (state == ST_CONVERT);
        sclk       = sclk_q;
        shift_en   = (state == ST_READ) && sclk_q;
        mux_sel    = mux_q;
        push_valid = (state == ST_SETTLE) && (push_idx < IDX_W'(NUM_CONV));
        fifo_wr    = push_valid && !fifo_full;
        lane_idx   = push_idx[LANE_W-1:0];
    end

endmodule

// File: rtl/adcseq_outmux.sv
// Picks the result for the current push and tags it with its channel number.
module adcseq_outmux #(
    parameter int NUM_CONV = 8,
    parameter int RES_W    = 14
) (
    input  logic [NUM_CONV-1:0][RES_W-1:0]     words,
    input  logic [$clog2(NUM_CONV)-1:0]        lane_idx,
    input  logic                               group,
    output logic [$clog2(NUM_CONV)+RES_W:0]    fifo_data
);

    always_comb begin
        fifo_data = {group, lane_idx, words[lane_idx]};
    end

endmodule

// File: rtl/adc_group_seq.sv
module adc_group_seq #(
    parameter int NUM_CONV    = 8,
    parameter int RES_W       = 14,
    parameter int CONV_CYCLES = 24,
    parameter int SETTLE_W    = 8,
    localparam int LANE_W     = $clog2(NUM_CONV),
    localparam int OUT_W      = LANE_W + 1 + RES_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                scan_mode,
    input  logic                group_sel,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                fifo_full,
    input  logic [NUM_CONV-1:0] sdata,
    output logic                mux_sel,
    output logic                hold,
    output logic                sclk,
    output logic                fifo_wr,
    output logic [OUT_W-1:0]    fifo_data
);

    logic                          shift_en;
    logic [LANE_W-1:0]             lane_idx;
    logic [NUM_CONV-1:0][RES_W-1:0] words;

    adcseq_ctrl #(
        .NUM_CONV    (NUM_CONV),
        .RES_W       (RES_W),
        .CONV_CYCLES (CONV_CYCLES),
        .SETTLE_W    (SETTLE_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .scan_mode     (scan_mode),
        .group_sel     (group_sel),
        .settle_cycles (settle_cycles),
        .fifo_full     (fifo_full),
        .hold          (hold),
        .sclk          (sclk),
        .shift_en      (shift_en),
        .mux_sel       (mux_sel),
        .fifo_wr       (fifo_wr),
        .lane_idx      (lane_idx)
    );

    for (genvar g = 0; g < NUM_CONV; g++) begin : g_lane
        adcseq_lane #(.RES_W(RES_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .shift_en  (shift_en),
            .sdata_bit (sdata[g]),
            .word      (words[g])
        );
    end

    adcseq_outmux #(
        .NUM_CONV (NUM_CONV),
        .RES_W    (RES_W)
    ) u_outmux (
        .words     (words),
        .lane_idx  (lane_idx),
        .group     (mux_sel),
        .fifo_data (fifo_data)
    );

endmodule

// File: rtl/adc_group_seq_chk.sv
module adc_group_seq_chk #(
    parameter int NUM_CONV = 8,
    parameter int RES_W    = 14,
    localparam int LANE_W  = $clog2(NUM_CONV),
    localparam int IDX_W   = $clog2(NUM_CONV + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic              sclk,
    input logic              mux_sel,
    input logic              fifo_full,
    input logic              fifo_wr,
    input logic [LANE_W:0]   chan
);

    logic [IDX_W-1:0] wr_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen <= '0;
        end else if (hold) begin
            wr_seen <= '0;
        end else if (fifo_wr) begin
            wr_seen <= wr_seen + IDX_W'(1);
        end
    end

    assert_hold_sclk_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold && sclk));

    assert_no_write_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_wr);

    assert_mux_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!hold || $stable(mux_sel)));

    assert_sclk_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> !sclk);

    assert_chan_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (wr_seen < IDX_W'(NUM_CONV))
                    && (chan == {mux_sel, wr_seen[LANE_W-1:0]}));

    assert_quiet_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!hold && !sclk));

endmodule

bind adc_group_seq adc_group_seq_chk #(
    .NUM_CONV (NUM_CONV),
    .RES_W    (RES_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .sclk      (sclk),
    .mux_sel   (mux_sel),
    .fifo_full (fifo_full),
    .fifo_wr   (fifo_wr),
    .chan      (fifo_data[RES_W +: $clog2(NUM_CONV)+1])
);

// File: tb/adc_group_seq_test.sv
`timescale 1ns/1ps
module adc_group_seq_test;

    localparam int CONV = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        scan_mode = 1'b0;
    logic        group_sel = 1'b0;
    logic [7:0]  settle_cycles = 8'd3;
    logic        fifo_full = 1'b0;
    logic [7:0]  sdata = 8'h00;
    logic        mux_sel, hold, sclk, fifo_wr;
    logic [17:0] fifo_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    adc_group_seq uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .scan_mode(scan_mode),
        .group_sel(group_sel), .settle_cycles(settle_cycles), .fifo_full(fifo_full),
        .sdata(sdata), .mux_sel(mux_sel), .hold(hold), .sclk(sclk),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    // Behavioural model: 0 idle, 1 select, 2 convert, 3 read, 4 settle
    int m_st = 0, m_cnt = 0, m_bit = 0, m_sclk = 0, m_grp = 0, m_next = 0, m_idx = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_bit = 0; m_sclk = 0; m_grp = 0; m_next = 0; m_idx = 0;
        end else begin
            case (m_st)
                0: if (enable) begin
                    m_grp = scan_mode ? m_next : int'(group_sel);
                    m_next = 1 - m_grp; m_st = 1;
                end
                1: begin m_st = 2; m_cnt = CONV - 1; end
                2: if (m_cnt == 0) begin m_st = 3; m_bit = 0; m_sclk = 0; end
                   else m_cnt--;
                3: if (m_sclk == 0) m_sclk = 1;
                   else begin
                       m_sclk = 0;
                       if (m_bit == 13) begin m_st = 4; m_cnt = int'(settle_cycles); m_idx = 0; end
                       else m_bit++;
                   end
                4: begin
                    bit ex;
                    ex = (m_cnt == 0) && (m_idx == 8) && !fifo_full;
                    if (m_idx < 8 && !fifo_full) m_idx++;
                    if (m_cnt != 0) m_cnt--;
                    if (ex) begin
                        if (enable) begin
                            m_grp = scan_mode ? m_next : int'(group_sel);
                            m_next = 1 - m_grp; m_st = 1;
                        end else begin
                            m_next = 0; m_st = 0;
                        end
                    end
                end
                default: m_st = 0;
            endcase
        end
    end

    // Bench-side converters and expected-result queue
    int cvals[8];
    int conv_no = 0;
    int bcnt = 14;
    int exp_q[$];
    bit prev_hold = 0;
    int since_sclk = 0;
    int last_settle = 0;
    bit seen_sclk = 0;

    function automatic int make_val(int n, int c, int g);
        if (n % 5 == 1) return 14'h3FFF;
        if (n % 5 == 2) return 0;
        return (n * 911 + g * 3001 + c * 1237 + 5) & 14'h3FFF;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int eh, es, ew;
            eh = (m_st == 2);
            es = (m_st == 3) && (m_sclk == 1);
            ew = (m_st == 4) && (m_idx < 8) && !fifo_full;
            chk(hold == eh[0], "R2 hold", hold, eh);
            chk(sclk == es[0], "R3 sclk", sclk, es);
            chk(mux_sel == m_grp[0], "R7 mux_sel", mux_sel, m_grp);
            chk(fifo_wr == ew[0], fifo_full ? "R6 fifo_wr" : "R4 fifo_wr", fifo_wr, ew);
            chk(!(hold && sclk), "R9 hold/sclk overlap", {hold, sclk}, 0);
            if (fifo_wr) begin
                if (exp_q.size() == 0) chk(0, "R4 unexpected write", fifo_data, 0);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(fifo_data == e[17:0], "R4 fifo_data", fifo_data, e);
                end
            end
            if (hold && !prev_hold) begin
                chk(exp_q.size() == 0, "R5 writes pending at hold", exp_q.size(), 0);
                if (seen_sclk)
                    chk(since_sclk >= last_settle + 2, "R5 settle gap", since_sclk, last_settle + 2);
                conv_no++;
                for (int c = 0; c < 8; c++) begin
                    cvals[c] = make_val(conv_no, c, int'(mux_sel));
                    exp_q.push_back(((int'(mux_sel) * 8 + c) << 14) | cvals[c]);
                end
                bcnt = 0;
            end
            prev_hold = hold;
            if (sclk) begin
                since_sclk = 0; seen_sclk = 1; last_settle = int'(settle_cycles);
            end else since_sclk++;
            for (int c = 0; c < 8; c++)
                sdata[c] = (bcnt < 14) ? cvals[c][13 - bcnt] : ((cyc + c) % 2 == 1);
            if (sclk && bcnt < 14) bcnt++;
        end
    end

    task automatic wait_convs(input int n);
        int target;
        target = conv_no + n;
        while (conv_no < target) @(posedge clk);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
    endtask

    initial begin : wdog
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        // R1: quiet outputs in reset
        chk(!hold && !sclk && !fifo_wr && !mux_sel, "R1 reset outputs",
            {hold, sclk, fifo_wr, mux_sel}, 0);
        rst_n = 1'b1;
        step(4);
        chk(!hold && !sclk && !fifo_wr, "R1 idle outputs", {hold, sclk, fifo_wr}, 0);

        // single group 0, short settle: pushes decide the end of SETTLE
        enable = 1; scan_mode = 0; group_sel = 0; settle_cycles = 3;
        wait_convs(2); step(1);
        // single group 1, long settle: countdown decides
        group_sel = 1; settle_cycles = 20;
        wait_convs(2); step(1);
        // scan mode, zero settle
        scan_mode = 1; settle_cycles = 0;
        wait_convs(4); step(1);
        // FIFO full patterns landing on writes and on the settle end
        settle_cycles = 9;
        for (int i = 0; i < 400; i++) begin
            fifo_full = ((i % 7) < 3);
            step(1);
        end
        fifo_full = 1; step(150);
        fifo_full = 0; step(1);
        wait_convs(1);
        // R8: drop enable mid-conversion; must finish and go idle
        step(5);
        enable = 0;
        step(200);
        chk(exp_q.size() == 0, "R8 conversion completed", exp_q.size(), 0);
        for (int i = 0; i < 40; i++) begin
            step(1);
            chk(!hold && !sclk, "R8 idle stays quiet", {hold, sclk}, 0);
        end
        // R7: scan restarts at group 0 after idle
        enable = 1; scan_mode = 1; settle_cycles = 2;
        wait_convs(1);
        @(negedge clk);
        chk(mux_sel == 1'b0, "R7 scan restart group", mux_sel, 0);
        wait_convs(1);
        @(negedge clk);
        chk(mux_sel == 1'b1, "R7 scan second group", mux_sel, 1);
        step(100);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule